// File: doc/BRIEF.md
# Shared Buffer Channel Allocator

This block hands out a small pool of shared communication buffers to processing elements that need to pass data from one producer to one or more consumers. A producer opens a channel with a command that names itself, a logical channel slot and a bitmask of consumers. The controller looks at its busy register and takes the lowest-numbered free buffer. It then writes one routing lookup entry per participant, one per cycle, so that the producer and every consumer reach the same physical buffer through that slot. While those entries are being written, data accesses from the participants are held off.

Every word of every buffer has a valid bit. A producer write stores the data and sets the bit. A consumer read of a word that has not been written yet returns an INVALID status with no data. The consumer is expected to try again, and the block refuses a repeat read from that requester until a fixed retry interval has passed. The producer ends its part with a close command and each consumer ends with an end command. Each of these removes that requester's entry. When the close and all expected end commands have arrived, the buffer returns to the pool with its valid bits cleared. A consumer may hold entries in several slots at once, so it can gather data from several producers.

Top module: `shared_chan_alloc`

## Requirements
- R1: After reset cmd_ready is 1, cmd_done and rsp_valid are 0, no buffer is busy, and every data access returns status DENIED (3).
- R2: An open command (cmd_op 1) with N consumers, accepted in cycle c, takes the lowest-indexed free buffer. cmd_ready is low in cycles c+1 to c+N+1. In cycle c+N+2, cmd_done is 1 with cmd_status OK (0) and cmd_buf set to that buffer.
- R3: An open command that arrives while all buffers are busy completes in cycle c+1 with status FULL (1). No lookup entry changes.
- R4: An open command is refused with status BAD (2) if its consumer mask is empty, if the mask contains the producer, or if the named slot is already in use by the producer or by any consumer. BAD takes precedence over FULL.
- R5: While lookup entries are being written, accesses from the producer or the consumers of the channel being opened return BLOCKED (2). Accesses from other requesters are served normally.
- R6: A producer write through a live entry returns OK and sets the word's valid bit. A read of a valid word returns OK (0) with the stored data. Each access accepted in cycle c is answered with rsp_valid in cycle c+1.
- R7: A read of a word whose valid bit is clear returns INVALID (1) with rsp_rdata 0.
- R8: After an INVALID read by requester r accepted in cycle c, reads by r accepted in cycles c+1 to c+RETRY_GAP-1 return BACKOFF (4) and touch nothing. A read accepted in cycle c+RETRY_GAP is served.
- R9: An access through a slot with no live entry returns DENIED. A consumer write returns DENIED and does not set the valid bit.
- R10: A close (cmd_op 2) from the producer or an end (cmd_op 3) from a consumer returns OK with the channel's buffer and removes that requester's entry. The buffer becomes free only after the close and all consumer ends, in either order. A reopened buffer starts with all valid bits clear.
- R11: A close from a requester whose entry is not a producer entry, or an end from a requester whose entry is not a consumer entry or who has no entry, returns BAD.
- R12: A consumer with entries in two slots reads the data of two different producers through those slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 1 open, 2 close, 3 end |
| cmd_src | input | RW | Requester issuing the command |
| cmd_slot | input | SW | Logical channel slot |
| cmd_cons | input | NUM_REQ | Consumer mask (open only) |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_status | output | 2 | 0 OK, 1 FULL, 2 BAD |
| cmd_buf | output | BW | Buffer affected by the command |
| acc_valid | input | 1 | Data access present |
| acc_src | input | RW | Accessing requester |
| acc_slot | input | SW | Slot used for the access |
| acc_we | input | 1 | 1 write, 0 read |
| acc_addr | input | AW | Word address within the buffer |
| acc_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Access response present |
| rsp_status | output | 3 | 0 OK, 1 INVALID, 2 BLOCKED, 3 DENIED, 4 BACKOFF |
| rsp_rdata | output | DATA_W | Read data, 0 unless a read is OK |

## Verification
The assertions assume that at most one command and one access arrive per cycle, and that a command is held only while cmd_ready is high. They also assume cmd_op values are legal and requester and slot indices are in range. The bench drives each command for exactly one cycle and waits for cmd_done before sending the next. It issues blocked accesses only during the programming window of an open. After every INVALID read it leaves the retry gap idle, unless the backoff behaviour itself is under test.

// File: rtl/chan_pkg.sv
// Shared types of the channel allocator: command opcodes and status codes.
package chan_pkg;
    typedef enum logic [1:0] {OP_NOP = 2'd0, OP_OPEN = 2'd1, OP_CLOSE = 2'd2, OP_END = 2'd3} chan_op_e;
    typedef enum logic [1:0] {CS_OK = 2'd0, CS_FULL = 2'd1, CS_BAD = 2'd2} cmd_stat_e;
    typedef enum logic [2:0] {AS_OK = 3'd0, AS_INVALID = 3'd1, AS_BLOCKED = 3'd2,
                              AS_DENIED = 3'd3, AS_BACKOFF = 3'd4} acc_stat_e;
endpackage

// File: rtl/chan_lookup.sv
// Routing lookup: one entry per (requester, slot) holding a live flag, the
// physical buffer and the role. Assumes one write and one invalidate per
// cycle at most, never to the same entry in the same cycle.
module chan_lookup #(
    parameter int NUM_REQ  = 4,
    parameter int NUM_SLOT = 2,
    parameter int NUM_BUF  = 2,
    localparam int RW = (NUM_REQ  > 1) ? $clog2(NUM_REQ)  : 1,
    localparam int SW = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
    localparam int BW = (NUM_BUF  > 1) ? $clog2(NUM_BUF)  : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RW-1:0]      wr_req,
    input  logic [SW-1:0]      wr_slot,
    input  logic [BW-1:0]      wr_buf,
    input  logic               wr_prod,
    input  logic               inv_en,
    input  logic [RW-1:0]      inv_req,
    input  logic [SW-1:0]      inv_slot,
    input  logic [RW-1:0]      ra_req,
    input  logic [SW-1:0]      ra_slot,
    output logic               ra_valid,
    output logic [BW-1:0]      ra_buf,
    output logic               ra_prod,
    input  logic [RW-1:0]      rb_req,
    input  logic [SW-1:0]      rb_slot,
    output logic               rb_valid,
    output logic [BW-1:0]      rb_buf,
    output logic               rb_prod,
    output logic [NUM_REQ-1:0] q_used
);
    logic          ent_valid [NUM_REQ][NUM_SLOT];
    logic          ent_prod  [NUM_REQ][NUM_SLOT];
    logic [BW-1:0] ent_buf   [NUM_REQ][NUM_SLOT];

    // Entry update: programming writes and close/end invalidations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REQ; r++) begin
                for (int s = 0; s < NUM_SLOT; s++) begin
                    ent_valid[r][s] <= 1'b0;
                    ent_prod[r][s]  <= 1'b0;
                    ent_buf[r][s]   <= '0;
                end
            end
        end else begin
            if (wr_en) begin
                ent_valid[wr_req][wr_slot] <= 1'b1;
                ent_prod[wr_req][wr_slot]  <= wr_prod;
                ent_buf[wr_req][wr_slot]   <= wr_buf;
            end
            if (inv_en) begin
                ent_valid[inv_req][inv_slot] <= 1'b0;
            end
        end
    end

    // Access-side read port.
    always_comb begin
        ra_valid = ent_valid[ra_req][ra_slot];
        ra_buf   = ent_buf[ra_req][ra_slot];
        ra_prod  = ent_prod[ra_req][ra_slot];
    end

    // Command-side read port.
    always_comb begin
        rb_valid = ent_valid[rb_req][rb_slot];
        rb_buf   = ent_buf[rb_req][rb_slot];
        rb_prod  = ent_prod[rb_req][rb_slot];
    end

    // Slot occupancy across all requesters for the command's slot.
    always_comb begin
        for (int r = 0; r < NUM_REQ; r++) begin
            q_used[r] = ent_valid[r][rb_slot];
        end
    end
endmodule

// File: rtl/chan_bufbank.sv
// Shared buffers with a valid bit per word. A write sets the word's bit;
// a release clears every bit of one buffer and wins over a same-cycle write.
module chan_bufbank #(
    parameter int NUM_BUF   = 2,
    parameter int BUF_DEPTH = 4,
    parameter int DATA_W    = 8,
    localparam int BW = (NUM_BUF   > 1) ? $clog2(NUM_BUF)   : 1,
    localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BW-1:0]     sel_buf,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              clr_en,
    input  logic [BW-1:0]     clr_buf
);
    logic [DATA_W-1:0]    mem  [NUM_BUF][BUF_DEPTH];
    logic [BUF_DEPTH-1:0] vbit [NUM_BUF];

    // Word storage, no reset needed: guarded by the valid bits.
    always_ff @(posedge clk) begin
        if (we) mem[sel_buf][addr] <= wdata;
    end

    // Valid bits: set on write, cleared per buffer on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BUF; b++) vbit[b] <= '0;
        end else begin
            if (we) vbit[sel_buf][addr] <= 1'b1;
            if (clr_en) vbit[clr_buf] <= '0;
        end
    end

    // Combinational read of data and its valid bit.
    always_comb begin
        rdata  = mem[sel_buf][addr];
        rvalid = vbit[sel_buf][addr];
    end
endmodule

// File: rtl/chan_ctrl.sv
// Channel controller: decodes open/close/end, keeps the busy register, the
// pending consumer counts and close flags, and programs lookup entries one
// per cycle. Assumes a command is presented only with cmd_ready high.
module chan_ctrl
    import chan_pkg::*;
#(
    parameter int NUM_REQ  = 4,
    parameter int NUM_SLOT = 2,
    parameter int NUM_BUF  = 2,
    localparam int RW = (NUM_REQ  > 1) ? $clog2(NUM_REQ)  : 1,
    localparam int SW = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
    localparam int BW = (NUM_BUF  > 1) ? $clog2(NUM_BUF)  : 1,
    localparam int CW = $clog2(NUM_REQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [RW-1:0]      cmd_src,
    input  logic [SW-1:0]      cmd_slot,
    input  logic [NUM_REQ-1:0] cmd_cons,
    output logic               cmd_ready,
    output logic               cmd_done,
    output logic [1:0]         cmd_status,
    output logic [BW-1:0]      cmd_buf,
    input  logic               rb_valid,
    input  logic [BW-1:0]      rb_buf,
    input  logic               rb_prod,
    input  logic [NUM_REQ-1:0] q_used,
    output logic               wr_en,
    output logic [RW-1:0]      wr_req,
    output logic [SW-1:0]      wr_slot,
    output logic [BW-1:0]      wr_buf,
    output logic               wr_prod,
    output logic               inv_en,
    output logic               clr_en,
    output logic [BW-1:0]      clr_buf,
    output logic               prog_active,
    output logic [NUM_REQ-1:0] involved,
    output logic [NUM_BUF-1:0] busy
);
    typedef enum logic {ST_IDLE, ST_PROG} st_e;

    st_e                state;
    logic [NUM_REQ-1:0] remaining;
    logic [RW-1:0]      prod_id;
    logic [SW-1:0]      slot_q;
    logic [BW-1:0]      cur_buf;
    logic [CW-1:0]      pend   [NUM_BUF];
    logic [NUM_BUF-1:0] closed;

    logic               accept, is_open, is_close, is_end;
    logic [NUM_REQ-1:0] src_oh, next_oh;
    logic [RW-1:0]      next_req;
    logic               open_bad, close_bad, end_bad, release_now, any_free, last_write;
    logic [BW-1:0]      free_idx;

    function automatic logic [CW-1:0] count_ones(input logic [NUM_REQ-1:0] v);
        logic [CW-1:0] n = '0;
        for (int i = 0; i < NUM_REQ; i++) n = n + CW'(v[i]);
        return n;
    endfunction

    // Command decode and legality checks.
    always_comb begin
        accept   = cmd_valid && (state == ST_IDLE);
        is_open  = cmd_op == OP_OPEN;
        is_close = cmd_op == OP_CLOSE;
        is_end   = cmd_op == OP_END;
        src_oh   = '0;
        src_oh[cmd_src] = 1'b1;
        open_bad  = (cmd_cons == '0) || ((cmd_cons & src_oh) != '0) ||
                    (((cmd_cons | src_oh) & q_used) != '0);
        close_bad = !rb_valid || !rb_prod;
        end_bad   = !rb_valid || rb_prod;
        release_now = accept && ((is_close && !close_bad && pend[rb_buf] == '0) ||
                                 (is_end && !end_bad && closed[rb_buf] &&
                                  pend[rb_buf] == CW'(1)));
    end

    // Lowest-indexed free buffer.
    always_comb begin
        any_free = ~&busy;
        free_idx = '0;
        for (int b = NUM_BUF - 1; b >= 0; b--) begin
            if (!busy[b]) free_idx = BW'(b);
        end
    end

    // Next participant to program: lowest remaining requester.
    always_comb begin
        next_req = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (remaining[i]) next_req = RW'(i);
        end
        next_oh = '0;
        next_oh[next_req] = 1'b1;
        last_write = (remaining & ~next_oh) == '0;
    end

    // Lookup and bank control outputs.
    always_comb begin
        wr_en       = state == ST_PROG;
        wr_req      = next_req;
        wr_slot     = slot_q;
        wr_buf      = cur_buf;
        wr_prod     = next_req == prod_id;
        inv_en      = accept && ((is_close && !close_bad) || (is_end && !end_bad));
        clr_en      = release_now;
        clr_buf     = rb_buf;
        cmd_ready   = state == ST_IDLE;
        prog_active = state == ST_PROG;
    end

    // Controller state, busy register, per-buffer bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            remaining  <= '0;
            involved   <= '0;
            prod_id    <= '0;
            slot_q     <= '0;
            cur_buf    <= '0;
            busy       <= '0;
            closed     <= '0;
            cmd_done   <= 1'b0;
            cmd_status <= CS_OK;
            cmd_buf    <= '0;
            for (int b = 0; b < NUM_BUF; b++) pend[b] <= '0;
        end else begin
            cmd_done <= 1'b0;
            if (state == ST_PROG) begin
                remaining <= remaining & ~next_oh;
                if (last_write) begin
                    state      <= ST_IDLE;
                    involved   <= '0;
                    cmd_done   <= 1'b1;
                    cmd_status <= CS_OK;
                    cmd_buf    <= cur_buf;
                end
            end else if (accept) begin
                cmd_done   <= 1'b1;
                cmd_status <= CS_BAD;
                cmd_buf    <= '0;
                if (is_open) begin
                    if (open_bad) begin
                        cmd_status <= CS_BAD;
                    end else if (!any_free) begin
                        cmd_status <= CS_FULL;
                    end else begin
                        cmd_done          <= 1'b0;
                        state             <= ST_PROG;
                        busy[free_idx]    <= 1'b1;
                        closed[free_idx]  <= 1'b0;
                        pend[free_idx]    <= count_ones(cmd_cons);
                        cur_buf           <= free_idx;
                        remaining         <= cmd_cons | src_oh;
                        involved          <= cmd_cons | src_oh;
                        prod_id           <= cmd_src;
                        slot_q            <= cmd_slot;
                    end
                end else if (is_close && !close_bad) begin
                    cmd_status      <= CS_OK;
                    cmd_buf         <= rb_buf;
                    closed[rb_buf]  <= 1'b1;
                end else if (is_end && !end_bad) begin
                    cmd_status    <= CS_OK;
                    cmd_buf       <= rb_buf;
                    pend[rb_buf]  <= pend[rb_buf] - CW'(1);
                end
                if (release_now) begin
                    busy[rb_buf]   <= 1'b0;
                    closed[rb_buf] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/chan_access.sv
// Data access path: classifies each access, drives the bank write, enforces
// the per-requester retry gap after INVALID reads and registers the response.
module chan_access
    import chan_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int DATA_W    = 8,
    parameter int RETRY_GAP = 3,
    localparam int RW = (NUM_REQ   > 1) ? $clog2(NUM_REQ)   : 1,
    localparam int GW = (RETRY_GAP > 2) ? $clog2(RETRY_GAP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [RW-1:0]      acc_src,
    input  logic               acc_we,
    input  logic               ent_valid,
    input  logic               ent_prod,
    input  logic               prog_active,
    input  logic [NUM_REQ-1:0] involved,
    input  logic [DATA_W-1:0]  bank_rdata,
    input  logic               bank_rvalid,
    output logic               bank_we,
    output logic               rsp_valid,
    output logic [2:0]         rsp_status,
    output logic [DATA_W-1:0]  rsp_rdata
);
    acc_stat_e st;
    logic      hold;
    logic      load_gap;

    // Classify the access against blocking, route, role, gap and valid bit.
    always_comb begin
        if (prog_active && involved[acc_src])  st = AS_BLOCKED;
        else if (!ent_valid)                   st = AS_DENIED;
        else if (acc_we)                       st = ent_prod ? AS_OK : AS_DENIED;
        else if (hold)                         st = AS_BACKOFF;
        else if (bank_rvalid)                  st = AS_OK;
        else                                   st = AS_INVALID;
        bank_we  = acc_valid && acc_we && (st == AS_OK);
        load_gap = acc_valid && !acc_we && (st == AS_INVALID);
    end

    if (RETRY_GAP > 1) begin : g_backoff
        logic [GW-1:0] gap_cnt [NUM_REQ];
        // Per-requester countdown started by an INVALID read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < NUM_REQ; r++) gap_cnt[r] <= '0;
            end else begin
                for (int r = 0; r < NUM_REQ; r++) begin
                    if (load_gap && acc_src == RW'(r)) gap_cnt[r] <= GW'(RETRY_GAP - 1);
                    else if (gap_cnt[r] != '0)         gap_cnt[r] <= gap_cnt[r] - GW'(1);
                end
            end
        end
        assign hold = gap_cnt[acc_src] != '0;
    end else begin : g_nogap
        assign hold = 1'b0;
    end

    // Registered response, data only for successful reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= AS_OK;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid  <= acc_valid;
            rsp_status <= st;
            rsp_rdata  <= (acc_valid && !acc_we && st == AS_OK) ? bank_rdata : '0;
        end
    end
endmodule

// File: rtl/shared_chan_alloc.sv
// Top of the shared buffer channel allocator: wires the controller, the
// routing lookup, the buffer bank and the access path together.
module shared_chan_alloc #(
    parameter int NUM_REQ   = 4,
    parameter int NUM_SLOT  = 2,
    parameter int NUM_BUF   = 2,
    parameter int BUF_DEPTH = 4,
    parameter int DATA_W    = 8,
    parameter int RETRY_GAP = 3,
    localparam int RW = (NUM_REQ   > 1) ? $clog2(NUM_REQ)   : 1,
    localparam int SW = (NUM_SLOT  > 1) ? $clog2(NUM_SLOT)  : 1,
    localparam int BW = (NUM_BUF   > 1) ? $clog2(NUM_BUF)   : 1,
    localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [RW-1:0]      cmd_src,
    input  logic [SW-1:0]      cmd_slot,
    input  logic [NUM_REQ-1:0] cmd_cons,
    output logic               cmd_ready,
    output logic               cmd_done,
    output logic [1:0]         cmd_status,
    output logic [BW-1:0]      cmd_buf,
    input  logic               acc_valid,
    input  logic [RW-1:0]      acc_src,
    input  logic [SW-1:0]      acc_slot,
    input  logic               acc_we,
    input  logic [AW-1:0]      acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic               rsp_valid,
    output logic [2:0]         rsp_status,
    output logic [DATA_W-1:0]  rsp_rdata
);
    logic               wr_en, wr_prod, inv_en, clr_en, prog_active;
    logic [RW-1:0]      wr_req;
    logic [SW-1:0]      wr_slot;
    logic [BW-1:0]      wr_buf, clr_buf, ra_buf, rb_buf;
    logic               ra_valid, ra_prod, rb_valid, rb_prod;
    logic [NUM_REQ-1:0] q_used, involved;
    logic [NUM_BUF-1:0] busy_vec;
    logic               bank_we, bank_rvalid;
    logic [DATA_W-1:0]  bank_rdata;

    chan_ctrl #(.NUM_REQ(NUM_REQ), .NUM_SLOT(NUM_SLOT), .NUM_BUF(NUM_BUF)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src(cmd_src),
        .cmd_slot(cmd_slot), .cmd_cons(cmd_cons),
        .cmd_ready(cmd_ready), .cmd_done(cmd_done), .cmd_status(cmd_status), .cmd_buf(cmd_buf),
        .rb_valid(rb_valid), .rb_buf(rb_buf), .rb_prod(rb_prod), .q_used(q_used),
        .wr_en(wr_en), .wr_req(wr_req), .wr_slot(wr_slot), .wr_buf(wr_buf), .wr_prod(wr_prod),
        .inv_en(inv_en), .clr_en(clr_en), .clr_buf(clr_buf),
        .prog_active(prog_active), .involved(involved), .busy(busy_vec)
    );

    chan_lookup #(.NUM_REQ(NUM_REQ), .NUM_SLOT(NUM_SLOT), .NUM_BUF(NUM_BUF)) u_lookup (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_req(wr_req), .wr_slot(wr_slot), .wr_buf(wr_buf), .wr_prod(wr_prod),
        .inv_en(inv_en), .inv_req(cmd_src), .inv_slot(cmd_slot),
        .ra_req(acc_src), .ra_slot(acc_slot),
        .ra_valid(ra_valid), .ra_buf(ra_buf), .ra_prod(ra_prod),
        .rb_req(cmd_src), .rb_slot(cmd_slot),
        .rb_valid(rb_valid), .rb_buf(rb_buf), .rb_prod(rb_prod),
        .q_used(q_used)
    );

    chan_bufbank #(.NUM_BUF(NUM_BUF), .BUF_DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(bank_we), .sel_buf(ra_buf), .addr(acc_addr), .wdata(acc_wdata),
        .rdata(bank_rdata), .rvalid(bank_rvalid),
        .clr_en(clr_en), .clr_buf(clr_buf)
    );

    chan_access #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .RETRY_GAP(RETRY_GAP)) u_access (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_src(acc_src), .acc_we(acc_we),
        .ent_valid(ra_valid), .ent_prod(ra_prod),
        .prog_active(prog_active), .involved(involved),
        .bank_rdata(bank_rdata), .bank_rvalid(bank_rvalid), .bank_we(bank_we),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/chan_alloc_chk.sv
// Property checker for the channel allocator, bound to the top module.
// Assumes single-cycle commands presented only while cmd_ready is high.
module chan_alloc_chk
    import chan_pkg::*;
#(
    parameter int NUM_BUF = 2,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic               cmd_ready,
    input logic               cmd_done,
    input logic [1:0]         cmd_status,
    input logic               acc_valid,
    input logic               rsp_valid,
    input logic [2:0]         rsp_status,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic [NUM_BUF-1:0] busy
);
    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n) cmd_done |-> cmd_ready); // R2
    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n) $countones(busy & ~$past(busy)) <= 1); // R2
    AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_OPEN && (&busy)) |=> (cmd_done && cmd_status != CS_OK)); // R3
    AST_BLOCK_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == AS_BLOCKED) |-> $past(!cmd_ready)); // R5
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) acc_valid |=> rsp_valid); // R6
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !acc_valid |=> !rsp_valid); // R6
    AST_NODATA_UNLESS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != AS_OK) |-> rsp_rdata == '0); // R7
    AST_OPEN_NEVER_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_OPEN) |=> ((busy & $past(busy)) == $past(busy))); // R10
endmodule

bind shared_chan_alloc chan_alloc_chk #(.NUM_BUF(NUM_BUF), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .acc_valid(acc_valid), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .busy(busy_vec)
);

// File: tb/sim_shared_chan_alloc.sv
// Self-checking bench: 4 requesters, 2 slots, 2 buffers of 4 words, gap 3.
module sim_shared_chan_alloc;
    localparam int GAP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [1:0] cmd_src = 2'd0;
    logic       cmd_slot = 1'b0;
    logic [3:0] cmd_cons = 4'd0;
    logic       cmd_ready, cmd_done;
    logic [1:0] cmd_status;
    logic       cmd_buf;
    logic       acc_valid = 1'b0;
    logic [1:0] acc_src = 2'd0;
    logic       acc_slot = 1'b0;
    logic       acc_we = 1'b0;
    logic [1:0] acc_addr = 2'd0;
    logic [7:0] acc_wdata = 8'd0;
    logic       rsp_valid;
    logic [2:0] rsp_status;
    logic [7:0] rsp_rdata;

    int nrun = 0;
    int nfail = 0;

    shared_chan_alloc #(.NUM_REQ(4), .NUM_SLOT(2), .NUM_BUF(2), .BUF_DEPTH(4),
                        .DATA_W(8), .RETRY_GAP(GAP)) u0 (.*);

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nrun++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acc(input int src, input int slot, input int we, input int addr,
                       input int wd, output int st, output int rd);
        acc_valid = 1'b1; acc_src = 2'(src); acc_slot = 1'(slot);
        acc_we = 1'(we); acc_addr = 2'(addr); acc_wdata = 8'(wd);
        @(negedge clk);
        st = int'(rsp_status); rd = int'(rsp_rdata);
        acc_valid = 1'b0;
    endtask

    task automatic cmd(input int op, input int src, input int slot, input int cons,
                       output int st, output int bf, output int lat);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_src = 2'(src);
        cmd_slot = 1'(slot); cmd_cons = 4'(cons);
        lat = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!cmd_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        st = int'(cmd_status); bf = int'(cmd_buf);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

    initial begin
        int st, rd, bf, lat;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", int'(cmd_ready), 1);
        chk("R1 done", int'(cmd_done), 0);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        acc(1, 0, 0, 0, 0, st, rd);
        chk("R1 denied after reset", st, 3);

        // R2: open 0 -> {1,2} on slot 0
        cmd(1, 0, 0, 4'b0110, st, bf, lat);
        chk("R2 open status", st, 0);
        chk("R2 open buffer", bf, 0);
        chk("R2 open latency", lat, 4);

        // R6/R7: producer fills words 0,1; both consumers sweep all words
        for (int a = 0; a < 2; a++) begin
            acc(0, 0, 1, a, 8'h10 + a, st, rd);
            chk("R6 producer write", st, 0);
        end
        for (int c = 1; c <= 2; c++) begin
            for (int a = 0; a < 4; a++) begin
                acc(c, 0, 0, a, 0, st, rd);
                if (a < 2) begin
                    chk("R6 read status", st, 0);
                    chk("R6 read data", rd, 8'h10 + a);
                end else begin
                    chk("R7 unwritten status", st, 1);
                    chk("R7 unwritten data", rd, 0);
                    idle(GAP - 1);
                end
            end
        end

        // R8: retry gap
        acc(1, 0, 0, 3, 0, st, rd); chk("R8 first invalid", st, 1);
        acc(1, 0, 0, 3, 0, st, rd); chk("R8 backoff +1", st, 4);
        acc(1, 0, 0, 3, 0, st, rd); chk("R8 backoff +2", st, 4);
        acc(1, 0, 0, 3, 0, st, rd); chk("R8 served at gap", st, 1);
        acc(0, 0, 1, 3, 8'h33, st, rd); chk("R8 write during gap", st, 0);
        idle(1);
        acc(1, 0, 0, 3, 0, st, rd); chk("R8 retry ok", st, 0); chk("R8 retry data", rd, 8'h33);

        // R9: consumer write denied, no route denied
        acc(1, 0, 1, 2, 8'h77, st, rd); chk("R9 consumer write", st, 3);
        acc(2, 0, 0, 2, 0, st, rd); chk("R9 word still invalid", st, 1);
        idle(GAP - 1);
        acc(3, 0, 0, 0, 0, st, rd); chk("R9 no entry read", st, 3);
        acc(3, 1, 1, 0, 1, st, rd); chk("R9 no entry write", st, 3);

        // R5: open 3 -> {1} on slot 1, accesses during programming
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_src = 2'd3; cmd_slot = 1'b1; cmd_cons = 4'b0010;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 ready low while programming", int'(cmd_ready), 0);
        acc(1, 0, 0, 0, 0, st, rd); chk("R5 involved blocked", st, 2);
        acc(2, 0, 0, 0, 0, st, rd); chk("R5 uninvolved served", st, 0);
        chk("R5 uninvolved data", rd, 8'h10);
        chk("R2 second open done", int'(cmd_done), 1);
        chk("R2 second open status", int'(cmd_status), 0);
        chk("R2 second open buffer", int'(cmd_buf), 1);
        idle(1);

        // R12: consumer 1 gathers from two producers
        acc(3, 1, 1, 0, 8'hA0, st, rd); chk("R12 producer b write", st, 0);
        acc(1, 1, 0, 0, 0, st, rd); chk("R12 slot1 data", rd, 8'hA0);
        acc(1, 0, 0, 1, 0, st, rd); chk("R12 slot0 data", rd, 8'h11);

        // R3: all busy
        cmd(1, 2, 1, 4'b0001, st, bf, lat);
        chk("R3 full status", st, 1); chk("R3 full latency", lat, 1);
        acc(2, 1, 0, 0, 0, st, rd); chk("R3 producer untouched", st, 3);
        acc(0, 1, 0, 0, 0, st, rd); chk("R3 consumer untouched", st, 3);

        // R4: malformed opens
        cmd(1, 0, 1, 4'b0000, st, bf, lat); chk("R4 empty mask", st, 2);
        cmd(1, 0, 1, 4'b0001, st, bf, lat); chk("R4 self in mask", st, 2);
        cmd(1, 2, 0, 4'b0001, st, bf, lat); chk("R4 slot in use", st, 2);

        // R11: wrong-role close/end
        cmd(2, 1, 0, 0, st, bf, lat); chk("R11 close by consumer", st, 2);
        cmd(3, 0, 0, 0, st, bf, lat); chk("R11 end by producer", st, 2);
        cmd(3, 3, 0, 0, st, bf, lat); chk("R11 end without entry", st, 2);

        // R10: close first, then ends
        cmd(2, 0, 0, 0, st, bf, lat); chk("R10 close ok", st, 0); chk("R10 close buffer", bf, 0);
        acc(0, 0, 1, 0, 1, st, rd); chk("R10 producer entry gone", st, 3);
        cmd(1, 2, 1, 4'b0001, st, bf, lat); chk("R10 not freed by close", st, 1);
        cmd(3, 1, 0, 0, st, bf, lat); chk("R10 first end", st, 0);
        cmd(1, 2, 1, 4'b0001, st, bf, lat); chk("R10 not freed by one end", st, 1);
        cmd(3, 2, 0, 0, st, bf, lat); chk("R10 last end", st, 0);
        acc(1, 0, 0, 0, 0, st, rd); chk("R10 consumer entry gone", st, 3);
        cmd(1, 2, 1, 4'b0001, st, bf, lat);
        chk("R10 reopen status", st, 0); chk("R10 reopen buffer", bf, 0); chk("R10 reopen latency", lat, 3);
        acc(0, 1, 0, 0, 0, st, rd); chk("R10 valid bits cleared", st, 1);
        idle(GAP - 1);

        // R10: end before close
        cmd(3, 1, 1, 0, st, bf, lat); chk("R10 end first", st, 0); chk("R10 end buffer", bf, 1);
        cmd(1, 1, 0, 4'b1000, st, bf, lat); chk("R10 held until close", st, 1);
        cmd(2, 3, 1, 0, st, bf, lat); chk("R10 close after end", st, 0);
        cmd(1, 1, 0, 4'b1000, st, bf, lat);
        chk("R10 freed after close", st, 0); chk("R10 freed buffer", bf, 1);

        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end
endmodule